// File: doc/BRIEF.md
# Four-Buffer Trace Ring Write Sequencer

This block sits between a producer of fixed-length trace records and a memory write port. Software provides four independent buffer base addresses and a common buffer length in dwords. The block turns every accepted record dword into one write request at the next free address. Buffer 0 is filled first, then buffers 1, 2 and 3. After buffer 3, writing wraps back to buffer 0 as long as tracing stays enabled. A full buffer raises a sticky done flag and a one-cycle interrupt pulse, so software can copy that buffer out while the others fill.

A small state machine controls the flow. Its states are `ST_IDLE`, `ST_RUN` and `ST_DRAIN`.

- **`ST_IDLE` to `ST_RUN`:** taken when the enable is seen high. This transition also rewinds the position to buffer 0, offset 0.
- **`ST_RUN` to `ST_IDLE`:** taken when the enable is low at a record boundary, or when the final dword of a record is accepted after the enable has dropped.
- **`ST_RUN` to `ST_DRAIN`:** taken when the enable drops in the middle of a record.
- **`ST_DRAIN` to `ST_IDLE`:** taken when the last dword of that record is accepted.

Records are never split, and a stop never leaves a record half written. The current buffer index and dword offset are always visible as status.

Top module: `trace_ring_seq`

## Requirements
- R1: After reset the block is in `ST_IDLE` with the following outputs: `in_ready` and `wr_valid` low, `done_flags` zero, `buf_irq` zero, `cur_idx` 0 and `cur_off` 0.
- R2: When the enable is high in `ST_IDLE`, the next clock edge moves the block to `ST_RUN` and sets `cur_idx` to 0 and `cur_off` to 0, whatever position was held before.
- R3: While a dword is being offered, `wr_addr` equals the base of buffer `cur_idx` plus 4 times `cur_off`, and `wr_data` equals `in_data`, in the same cycle. Base i occupies bits [i*ADDR_W +: ADDR_W] of `base_addrs`.
- R4: Each accepted dword (`wr_valid` and `wr_ready` both high) advances `cur_off` by one. The dword written at `cur_off == buf_dwords-1` instead sets `cur_off` to 0 and advances `cur_idx` by one.
- R5: When buffer 3 becomes full while the enable is high, writing continues at buffer 0, offset 0.
- R6: If the enable drops inside a record, the remaining dwords of that record are still accepted, and then `in_ready` and `wr_valid` stay low. If the enable is low at a record boundary, no further dword is accepted.
- R7: If buffer 3 fills while the enable is low, no wrap takes place. The block stops in `ST_IDLE` and accepts no further dword.
- R8: When buffer i becomes full, `done_flags[i]` is set and `buf_irq[i]` is high for exactly the one cycle after that edge. At most one `buf_irq` bit is high at a time.
- R9: A one on `done_clr[i]` clears `done_flags[i]` on the next edge. A set in that same cycle wins over the clear.
- R10: While `wr_ready` is low, `in_ready` is low and the position (`cur_idx`, `cur_off`) does not move.
- R11: With `buf_dwords` a nonzero multiple of `REC_DW`, a buffer always becomes full on the last dword of a record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trace_en | input | 1 | Tracing enable |
| base_addrs | input | 4*ADDR_W | Four buffer base addresses; buffer i uses bits [i*ADDR_W +: ADDR_W] |
| buf_dwords | input | OFF_W+1 | Buffer length in dwords (nonzero multiple of REC_DW) |
| in_valid | input | 1 | Record dword offered |
| in_data | input | 32 | Record dword |
| in_ready | output | 1 | Record dword accepted this cycle when high together with in_valid |
| wr_valid | output | 1 | Write request valid |
| wr_addr | output | ADDR_W | Byte address of the write |
| wr_data | output | 32 | Write data |
| wr_ready | input | 1 | Write port accepts the request |
| done_flags | output | 4 | Sticky per-buffer full flags, bit i for buffer i |
| done_clr | input | 4 | Write-one-to-clear for done_flags |
| buf_irq | output | 4 | One-cycle per-buffer full pulse |
| cur_idx | output | 2 | Current buffer index |
| cur_off | output | OFF_W | Current dword offset in the buffer |

## Verification
Three results are due at different times, and each check is sampled at the point where its result should have settled.

- **Write request:** `wr_valid`, `wr_addr`, `wr_data` and `in_ready` are combinational from the offered dword. They are checked 1 ns after the inputs are driven on the falling edge, before the accepting rising edge.
- **Position and state:** the position registers, the state and the done flags change on the rising edge that accepts the dword or sees the enable. They are checked at the falling edge that follows.
- **Interrupt pulse:** the pulse is registered from the full-buffer dword. It is checked high at the falling edge right after that acceptance and low one cycle later.

Stop behaviour is checked through the ports: a dword is offered after the stop, and the check expects neither `in_ready` nor `wr_valid`.

// File: rtl/trs_pkg.sv
package trs_pkg;

    localparam int NBUF  = 4;
    localparam int IDX_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } trs_state_e;

endpackage

// File: rtl/trs_fsm.sv
module trs_fsm
    import trs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trace_en,
    input  logic       beat,
    input  logic       rec_last,
    input  logic       rec_open,
    output trs_state_e state,
    output logic       start,
    output logic       go
);

    trs_state_e state_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (trace_en) state_nx = ST_RUN;
            end
            ST_RUN: begin
                if (!trace_en) begin
                    if (!rec_open)             state_nx = ST_IDLE;
                    else if (beat && rec_last) state_nx = ST_IDLE;
                    else                       state_nx = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (beat && rec_last) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        start = 1'b0;
        go    = 1'b0;
        unique case (state)
            ST_IDLE:  start = trace_en;
            ST_RUN:   go    = trace_en || rec_open;
            ST_DRAIN: go    = 1'b1;
            default: begin
                start = 1'b0;
                go    = 1'b0;
            end
        endcase
    end

    // R6: a started record is never left unfinished in idle
    a_r6_no_abandon: assert property (@(posedge clk) disable iff (!rst_n)
        rec_open |-> state != ST_IDLE);

    // R6: draining always ends once the closing dword is taken
    a_r6_drain_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && beat && rec_last) |=> state == ST_IDLE);

endmodule

// File: rtl/trs_ptr.sv
module trs_ptr
    import trs_pkg::*;
#(
    parameter int OFF_W  = 20,
    parameter int REC_DW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             beat,
    input  logic [OFF_W:0]   buf_dwords,
    output logic [IDX_W-1:0] idx,
    output logic [OFF_W-1:0] off,
    output logic             rec_last,
    output logic             rec_open,
    output logic             full_beat
);

    localparam int RC_W = (REC_DW > 1) ? $clog2(REC_DW) : 1;

    logic [RC_W-1:0] rec_cnt;
    logic [OFF_W:0]  buf_last;
    logic            at_end;

    assign buf_last  = buf_dwords - 1'b1;
    assign at_end    = ({1'b0, off} == buf_last);
    assign full_beat = beat && at_end;
    assign rec_last  = (rec_cnt == RC_W'(REC_DW - 1));
    assign rec_open  = (rec_cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx     <= '0;
            off     <= '0;
            rec_cnt <= '0;
        end else if (start) begin
            idx     <= '0;
            off     <= '0;
            rec_cnt <= '0;
        end else if (beat) begin
            rec_cnt <= rec_last ? '0 : rec_cnt + 1'b1;
            if (at_end) begin
                off <= '0;
                idx <= idx + 1'b1;
            end else begin
                off <= off + 1'b1;
            end
        end
    end

    a_r2_start_rewind: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (idx == '0 && off == '0));

    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !at_end) |=> (off == OFF_W'($past(off) + 1'b1) && idx == $past(idx)));

    a_r4_next_buf: assert property (@(posedge clk) disable iff (!rst_n)
        full_beat |=> (off == '0 && idx == IDX_W'($past(idx) + 1'b1)));

    a_r11_rec_align: assert property (@(posedge clk) disable iff (!rst_n)
        full_beat |-> rec_last);

endmodule

// File: rtl/trs_done.sv
module trs_done
    import trs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             full_beat,
    input  logic [IDX_W-1:0] idx,
    input  logic [NBUF-1:0]  done_clr,
    output logic [NBUF-1:0]  done_flags,
    output logic [NBUF-1:0]  buf_irq
);

    for (genvar g = 0; g < NBUF; g++) begin : g_buf
        logic set_g;
        assign set_g = full_beat && (idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                done_flags[g] <= 1'b0;
                buf_irq[g]    <= 1'b0;
            end else begin
                buf_irq[g] <= set_g;
                if (set_g)            done_flags[g] <= 1'b1;
                else if (done_clr[g]) done_flags[g] <= 1'b0;
            end
        end

        a_r8_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
            buf_irq[g] |-> done_flags[g]);

        a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
            (done_clr[g] && !set_g) |=> !done_flags[g]);
    end

    a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(buf_irq));

endmodule

// File: rtl/trace_ring_seq.sv
module trace_ring_seq
    import trs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 20,
    parameter int REC_DW = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trace_en,
    input  logic [4*ADDR_W-1:0]  base_addrs,
    input  logic [OFF_W:0]       buf_dwords,
    input  logic                 in_valid,
    input  logic [31:0]          in_data,
    output logic                 in_ready,
    output logic                 wr_valid,
    output logic [ADDR_W-1:0]    wr_addr,
    output logic [31:0]          wr_data,
    input  logic                 wr_ready,
    output logic [3:0]           done_flags,
    input  logic [3:0]           done_clr,
    output logic [3:0]           buf_irq,
    output logic [1:0]           cur_idx,
    output logic [OFF_W-1:0]     cur_off
);

    localparam int PAD_W = ADDR_W - OFF_W - 2;

    trs_state_e        state;
    logic              start, go, beat;
    logic              rec_last, rec_open, full_beat;
    logic [ADDR_W-1:0] base_arr [NBUF];
    logic [ADDR_W-1:0] byte_off;

    for (genvar g = 0; g < NBUF; g++) begin : g_base
        assign base_arr[g] = base_addrs[g*ADDR_W +: ADDR_W];
    end

    assign wr_valid = go && in_valid;
    assign in_ready = go && wr_ready;
    assign beat     = wr_valid && wr_ready;
    assign byte_off = {{PAD_W{1'b0}}, cur_off, 2'b00};
    assign wr_addr  = base_arr[cur_idx] + byte_off;
    assign wr_data  = in_data;

    trs_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .trace_en (trace_en),
        .beat     (beat),
        .rec_last (rec_last),
        .rec_open (rec_open),
        .state    (state),
        .start    (start),
        .go       (go)
    );

    trs_ptr #(.OFF_W(OFF_W), .REC_DW(REC_DW)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .beat       (beat),
        .buf_dwords (buf_dwords),
        .idx        (cur_idx),
        .off        (cur_off),
        .rec_last   (rec_last),
        .rec_open   (rec_open),
        .full_beat  (full_beat)
    );

    trs_done u_done (
        .clk        (clk),
        .rst_n      (rst_n),
        .full_beat  (full_beat),
        .idx        (cur_idx),
        .done_clr   (done_clr),
        .done_flags (done_flags),
        .buf_irq    (buf_irq)
    );

    // R10: a stalled write port freezes the ring position
    a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ready && state != ST_IDLE) |=> ($stable(cur_off) && $stable(cur_idx)));

    // R7: after a stop at the ring end nothing is written until re-enable
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !in_ready);

endmodule

// File: tb/trace_ring_seq_tb_top.sv
module trace_ring_seq_tb_top;

    localparam int ADDR_W = 32;
    localparam int OFF_W  = 20;
    localparam int REC_DW = 4;
    localparam int BUFDW  = 8;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                trace_en = 1'b0;
    logic [4*ADDR_W-1:0] base_addrs;
    logic [OFF_W:0]      buf_dwords = (OFF_W+1)'(BUFDW);
    logic                in_valid = 1'b0;
    logic [31:0]         in_data = '0;
    logic                in_ready, wr_valid;
    logic [ADDR_W-1:0]   wr_addr;
    logic [31:0]         wr_data;
    logic                wr_ready = 1'b1;
    logic [3:0]          done_flags, buf_irq;
    logic [3:0]          done_clr = '0;
    logic [1:0]          cur_idx;
    logic [OFF_W-1:0]    cur_off;

    int total = 0;
    int bad   = 0;

    logic [31:0] bases [4] = '{32'h1000_0000, 32'h2000_0000, 32'h3000_0000, 32'h4000_0000};
    assign base_addrs = {bases[3], bases[2], bases[1], bases[0]};

    always #4 clk = ~clk;

    trace_ring_seq #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .REC_DW(REC_DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .base_addrs(base_addrs),
        .buf_dwords(buf_dwords), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_ready(wr_ready), .done_flags(done_flags),
        .done_clr(done_clr), .buf_irq(buf_irq), .cur_idx(cur_idx), .cur_off(cur_off)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Offer one dword; expect it accepted at exp_addr (R3), commit on next edge
    task automatic push(input logic [31:0] d, input logic [31:0] exp_addr, input string req);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        #1;
        check(req, "wr_valid", 64'(wr_valid), 64'd1);
        check("R3", "wr_addr", 64'(wr_addr), 64'(exp_addr));
        check("R3", "wr_data", 64'(wr_data), 64'(d));
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic fill_buf(input int b, input string req);
        for (int k = 0; k < BUFDW; k++)
            push(32'hA000_0000 + 32'(b*16 + k), bases[b] + 32'(4*k), req);
        #1;
        check("R8", "irq on fill", 64'(buf_irq), 64'(4'b0001 << b));
        check("R8", "done set", 64'(done_flags[b]), 64'd1);
        check("R4", "idx advance", 64'(cur_idx), 64'((b + 1) % 4));
        check("R4", "off rewind", 64'(cur_off), 64'd0);
        @(negedge clk); #1;
        check("R8", "irq one cycle", 64'(buf_irq), 64'd0);
    endtask

    task automatic t_reset();
        #1;
        check("R1", "in_ready", 64'(in_ready), 64'd0);
        check("R1", "wr_valid", 64'(wr_valid), 64'd0);
        check("R1", "done_flags", 64'(done_flags), 64'd0);
        check("R1", "buf_irq", 64'(buf_irq), 64'd0);
        check("R1", "idx/off", 64'({cur_idx, cur_off}), 64'd0);
    endtask

    task automatic t_fill_and_wrap();
        @(negedge clk); trace_en = 1'b1;
        @(negedge clk); #1;
        check("R2", "start pos", 64'({cur_idx, cur_off}), 64'd0);
        for (int b = 0; b < 4; b++) fill_buf(b, "R4");
        check("R5", "all done", 64'(done_flags), 64'hF);
        push(32'hB000_0000, bases[0], "R5");
        #1;
        check("R5", "wrap off", 64'(cur_off), 64'd1);
    endtask

    task automatic t_clear();
        @(negedge clk); done_clr = 4'b0001;
        @(negedge clk); done_clr = 4'b0000; #1;
        check("R9", "w1c", 64'(done_flags), 64'hE);
    endtask

    task automatic t_drain();
        @(negedge clk); trace_en = 1'b0;
        for (int k = 1; k < REC_DW; k++)
            push(32'hC000_0000 + 32'(k), bases[0] + 32'(4*k), "R6");
        @(negedge clk); in_valid = 1'b1; #1;
        check("R6", "stopped in_ready", 64'(in_ready), 64'd0);
        check("R6", "stopped wr_valid", 64'(wr_valid), 64'd0);
        @(negedge clk); in_valid = 1'b0; #1;
        check("R6", "held off", 64'(cur_off), 64'(REC_DW));
    endtask

    task automatic t_restart_stall();
        @(negedge clk); trace_en = 1'b1;
        @(negedge clk); #1;
        check("R2", "rewind", 64'({cur_idx, cur_off}), 64'd0);
        wr_ready = 1'b0; in_valid = 1'b1; #1;
        check("R10", "in_ready low", 64'(in_ready), 64'd0);
        @(negedge clk); #1;
        check("R10", "off held", 64'(cur_off), 64'd0);
        wr_ready = 1'b1; in_valid = 1'b0;
        done_clr = 4'hF;
        @(negedge clk); done_clr = 4'h0; #1;
        check("R9", "clear all", 64'(done_flags), 64'd0);
    endtask

    task automatic t_no_wrap();
        for (int k = 0; k < 4*BUFDW; k++) begin
            push(32'hD000_0000 + 32'(k), bases[k / BUFDW] + 32'(4*(k % BUFDW)), "R7");
            if (k == 4*BUFDW - 4) trace_en = 1'b0;
        end
        #1;
        check("R8", "irq buf3", 64'(buf_irq), 64'h8);
        check("R7", "done all", 64'(done_flags), 64'hF);
        check("R11", "ends on record", 64'(cur_off), 64'd0);
        @(negedge clk); in_valid = 1'b1; #1;
        check("R7", "no wrap in_ready", 64'(in_ready), 64'd0);
        check("R7", "no wrap wr_valid", 64'(wr_valid), 64'd0);
        @(negedge clk); in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill_and_wrap();
        t_clear();
        t_drain();
        t_restart_stall();
        t_no_wrap();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule